// File: doc/BRIEF.md
# ADC Result Byte-Access Interface

This block is the processor-facing register window of an analog-to-digital converter. The conversion side stores four 16-bit results into a bank of slots, A to D. The processor reads those slots one byte at a time through an 8-bit request/response port.

Reading a slot's high byte also captures that slot's low byte into one shared holding latch. A later low-byte read, at any slot's low address, returns the holding latch. A 16-bit value read high byte first is therefore coherent, even if the converter overwrites the slot between the two reads. A low byte read on its own returns whatever the latch last captured, and the block does not correct this.

A one-bit arm flag, placed in an otherwise read-only control byte, decides whether falling edges on an external trigger pin start a conversion. A software start request starts a conversion at any time.

Requests use valid/ready. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. A read returns exactly one response, held in a single output stage. `req_ready` is low only while that stage holds a response the consumer has not yet taken (`rsp_valid` high, `rsp_ready` low). The response's data stays constant until it is taken. Writes produce no response.

Top module: `adc_bytebus_if`

## Requirements
- R1: An accepted read at an even offset 0, 2, 4 or 6 returns the high byte (bits 15:8) of slot A, B, C or D respectively.
- R2: An accepted high-byte read copies the addressed slot's low byte (bits 7:0), as stored before that clock edge, into the single shared holding latch.
- R3: An accepted read at an odd offset 1, 3, 5 or 7 returns the holding latch, whichever slot the offset names. The latch holds 0x00 after reset, and a low-byte read with no earlier high-byte read returns that stale value.
- R4: A conversion-side write into any slot leaves the holding latch unchanged. Only a high-byte read changes the latch.
- R5: The control byte sits at offset 8 and reads as {arm, 7'b1111111}. Only bit 7 (arm) is writable, and the byte resets to 0x7F.
- R6: While `standby` is high, the control byte is forced to 0x7F. This clears arm, and standby takes priority over a processor write in the same cycle.
- R7: Reads at offsets 9 to 15 return 0xFF. Processor writes to offsets 0 to 7 do not change any slot.
- R8: With arm at 0, the external trigger pin never produces `conv_start`. With arm at 1, a falling edge on the pin, passed through two synchroniser stages, produces a `conv_start` pulse exactly one cycle wide. The pulse is high during the second clock cycle after the first rising edge that samples the pin low.
- R9: `sw_start` drives `conv_start` high in the same cycle, whatever the value of arm.
- R10: A read response appears, with `rsp_valid` high, in the cycle after the request is accepted. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, and `rsp_valid` and `rsp_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Low-power mode; forces the control byte to 0x7F |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_data | output | 8 | Read data |
| res_wr_en | input | 1 | Conversion-side slot write strobe |
| res_wr_sel | input | 2 | Slot index, 0 = A to 3 = D |
| res_wr_data | input | 16 | Conversion result |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| sw_start | input | 1 | Software start request |
| conv_start | output | 1 | Conversion start pulse |

## Verification
Several behaviours are checked on every cycle by the assertions:
- the holding latch moves only on an accepted high-byte read;
- the control byte's low seven bits read as ones, and arm clears under standby;
- unmapped offsets read 0xFF;
- `conv_start` stays low when neither arm nor `sw_start` is set;
- the response stage holds steady under back-pressure.

Other behaviours can only be shown by the bench's scenarios, because they depend on values chosen outside the block:
- the actual byte values returned for each slot;
- the sharing of one latch between different slots;
- staleness after a converter overwrite;
- the exact cycle of the trigger pulse.

// File: rtl/adc_bif_pkg.sv
package adc_bif_pkg;
  localparam int NUM_SLOTS   = 4;
  localparam int SLOT_W      = 16;
  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = 4;
  localparam int SEL_W       = $clog2(NUM_SLOTS);
  localparam int CTRL_OFFSET = 2 * NUM_SLOTS;
  localparam logic [BYTE_W-1:0] UNMAPPED_BYTE = '1;
  localparam logic [BYTE_W-2:0] CTRL_FIXED    = '1;

  typedef enum logic [1:0] {
    REGION_SLOT,
    REGION_CTRL,
    REGION_NONE
  } region_e;
endpackage

// File: rtl/adc_slot_bank.sv
module adc_slot_bank #(
  parameter int NUM   = 4,
  parameter int WIDTH = 16,
  localparam int SW   = $clog2(NUM),
  localparam int HALF = WIDTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [SW-1:0]    rd_sel,
  output logic [HALF-1:0]  rd_hi,
  output logic [HALF-1:0]  rd_lo
);
  logic [WIDTH-1:0] slot_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (wr_en && (wr_sel == SW'(g))) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_hi = slot_q[rd_sel][WIDTH-1:HALF];
    rd_lo = slot_q[rd_sel][HALF-1:0];
  end
endmodule

// File: rtl/adc_ctrl_byte.sv
module adc_ctrl_byte #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              arm,
  output logic [BYTE_W-1:0] ctrl_byte
);
  logic arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
    end else if (standby) begin
      arm_q <= 1'b0;
    end else if (wr_en) begin
      arm_q <= wr_data[BYTE_W-1];
    end
  end

  assign arm       = arm_q;
  assign ctrl_byte = {arm_q, {(BYTE_W-1){1'b1}}};

  AST_STANDBY_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !arm_q); // R6
endmodule

// File: rtl/adc_trig_qual.sv
module adc_trig_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_trig,
  input  logic arm,
  input  logic sw_start,
  output logic conv_start
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_trig};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall       = prev_q && !sync_q[SYNC_STAGES-1];
  assign conv_start = sw_start || (arm && fall);

  AST_TRIG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !sw_start) |-> !conv_start); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !sw_start) |=> (!conv_start || sw_start)); // R8
  AST_SW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_start |-> conv_start); // R9
endmodule

// File: rtl/adc_bytebus_if.sv
module adc_bytebus_if
  import adc_bif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_data,
  input  logic              res_wr_en,
  input  logic [SEL_W-1:0]  res_wr_sel,
  input  logic [SLOT_W-1:0] res_wr_data,
  input  logic              ext_trig,
  input  logic              sw_start,
  output logic              conv_start
);
  localparam int HALF = SLOT_W / 2;

  logic              accept;
  logic              rd_acc;
  logic              wr_acc;
  region_e           region;
  logic [SEL_W-1:0]  slot_sel;
  logic              lo_sel;
  logic [HALF-1:0]   slot_hi;
  logic [HALF-1:0]   slot_lo;
  logic [BYTE_W-1:0] hold_q;
  logic [BYTE_W-1:0] ctrl_byte;
  logic              arm;
  logic              rsp_valid_q;
  logic [BYTE_W-1:0] rsp_data_q;
  logic [BYTE_W-1:0] rd_byte;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rd_acc    = accept && !req_write;
  assign wr_acc    = accept && req_write;

  always_comb begin
    if (int'(req_addr) < CTRL_OFFSET)       region = REGION_SLOT;
    else if (int'(req_addr) == CTRL_OFFSET) region = REGION_CTRL;
    else                                    region = REGION_NONE;
    slot_sel = req_addr[SEL_W:1];
    lo_sel   = req_addr[0];
  end

  adc_slot_bank #(.NUM(NUM_SLOTS), .WIDTH(SLOT_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (res_wr_en),
    .wr_sel  (res_wr_sel),
    .wr_data (res_wr_data),
    .rd_sel  (slot_sel),
    .rd_hi   (slot_hi),
    .rd_lo   (slot_lo)
  );

  adc_ctrl_byte #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby   (standby),
    .wr_en     (wr_acc && (region == REGION_CTRL)),
    .wr_data   (req_wdata),
    .arm       (arm),
    .ctrl_byte (ctrl_byte)
  );

  adc_trig_qual #(.SYNC_STAGES(2)) u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_trig   (ext_trig),
    .arm        (arm),
    .sw_start   (sw_start),
    .conv_start (conv_start)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (rd_acc && (region == REGION_SLOT) && !lo_sel) begin
      hold_q <= slot_lo;
    end
  end

  always_comb begin
    unique case (region)
      REGION_SLOT: rd_byte = lo_sel ? hold_q : slot_hi;
      REGION_CTRL: rd_byte = ctrl_byte;
      default:     rd_byte = UNMAPPED_BYTE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (rd_acc) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_byte;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  AST_HOLD_ONLY_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_acc && region == REGION_SLOT && !lo_sel) |=> $stable(hold_q)); // R4
  AST_LOW_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && region == REGION_SLOT && lo_sel) |=> rsp_data == $past(hold_q)); // R3
  AST_CTRL_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && region == REGION_CTRL) |=> rsp_data[BYTE_W-2:0] == CTRL_FIXED); // R5
  AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && region == REGION_NONE) |=> rsp_data == UNMAPPED_BYTE); // R7
  AST_RSP_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R10
  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R10
endmodule

// File: tb/adc_bytebus_if_test.sv
`timescale 1ns/1ps
module adc_bytebus_if_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic        res_wr_en = 1'b0;
  logic [1:0]  res_wr_sel = '0;
  logic [15:0] res_wr_data = '0;
  logic        ext_trig = 1'b1;
  logic        sw_start = 1'b0;
  logic        conv_start;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  adc_bytebus_if uut (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .res_wr_en(res_wr_en), .res_wr_sel(res_wr_sel), .res_wr_data(res_wr_data),
    .ext_trig(ext_trig), .sw_start(sw_start), .conv_start(conv_start)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: scoreboard pop on every completed response transfer
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected response", rsp_data, 0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rsp_data == e, t, rsp_data, e);
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic put_slot(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    res_wr_en = 1'b1; res_wr_sel = s; res_wr_data = d;
    @(negedge clk);
    res_wr_en = 1'b0;
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid, "R10 reset rsp_valid", rsp_valid, 0);
    chk(!conv_start, "R8 reset conv_start", conv_start, 0);
    rd(4'd8, 8'h7F, "R5 ctrl reset value");
    rd(4'd1, 8'h00, "R3 stale low read after reset");

    put_slot(2'd0, 16'h1234);
    put_slot(2'd1, 16'h5678);
    put_slot(2'd2, 16'h9ABC);
    put_slot(2'd3, 16'hDEF0);
    rd(4'd0, 8'h12, "R1 high A");
    rd(4'd3, 8'h34, "R2 shared latch via B offset");
    rd(4'd4, 8'h9A, "R1 high C");
    rd(4'd5, 8'hBC, "R3 low C");
    rd(4'd6, 8'hDE, "R1 high D");
    rd(4'd7, 8'hF0, "R3 low D");

    rd(4'd2, 8'h56, "R1 high B");
    put_slot(2'd1, 16'hAAAA);
    rd(4'd3, 8'h78, "R4 latch kept across slot write");
    rd(4'd2, 8'hAA, "R1 high B after update");
    rd(4'd1, 8'hAA, "R2 latch reloaded");

    wr(4'd0, 8'h55);
    rd(4'd0, 8'h12, "R7 slot write ignored");
    rd(4'd12, 8'hFF, "R7 unmapped 12");
    rd(4'd9, 8'hFF, "R7 unmapped 9");

    wr(4'd8, 8'h80);
    rd(4'd8, 8'hFF, "R5 arm set");
    wr(4'd8, 8'h00);
    rd(4'd8, 8'h7F, "R5 arm cleared");
    wr(4'd8, 8'hFF);
    @(negedge clk); standby = 1'b1;
    @(negedge clk); standby = 1'b0;
    rd(4'd8, 8'h7F, "R6 standby forces 0x7F");
    drain();

    // R8 disarmed: falling edge must not start
    begin
      int hits = 0;
      @(negedge clk); ext_trig = 1'b0;
      repeat (6) begin @(negedge clk); if (conv_start) hits++; end
      chk(hits == 0, "R8 disarmed trigger ignored", hits, 0);
      ext_trig = 1'b1;
      repeat (4) @(negedge clk);
    end

    // R8 armed: one pulse in the expected cycle
    wr(4'd8, 8'h80);
    drain();
    begin
      int hits = 0;
      @(negedge clk); ext_trig = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      chk(conv_start, "R8 armed pulse cycle", conv_start, 1);
      @(posedge clk); #1;
      chk(!conv_start, "R8 pulse one cycle wide", conv_start, 0);
      repeat (5) begin @(negedge clk); if (conv_start) hits++; end
      chk(hits == 0, "R8 no repeat while held low", hits, 0);
      ext_trig = 1'b1;
      repeat (4) @(negedge clk);
      chk(!conv_start, "R8 rising edge no pulse", conv_start, 0);
    end

    // R9 software start regardless of arm
    wr(4'd8, 8'h00);
    @(negedge clk); sw_start = 1'b1; #1;
    chk(conv_start, "R9 sw_start while disarmed", conv_start, 1);
    @(negedge clk); sw_start = 1'b0; #1;
    chk(!conv_start, "R9 sw_start released", conv_start, 0);

    // R10 back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd4;
    exp_q.push_back(8'h9A); tag_q.push_back("R10 stalled response data");
    @(negedge clk);
    req_addr = 4'd6;
    chk(rsp_valid, "R10 response next cycle", rsp_valid, 1);
    chk(!req_ready, "R10 ready low while stalled", req_ready, 0);
    @(negedge clk);
    chk(rsp_valid && rsp_data == 8'h9A, "R10 held while stalled", rsp_data, 8'h9A);
    exp_q.push_back(8'hDE); tag_q.push_back("R10 queued read after stall");
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    drain();
    chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule